// File: doc/BRIEF.md
# Instruction Fetch Router with Vector Load

This block sits between a processor core's instruction-fetch stage and two program stores: a small on-die ROM of 4 KB and an external program memory that spans the whole 16-bit address space. Each fetch address is routed to exactly one store. The choice depends on a boot strap pin and on whether the address falls inside the on-die ROM window. The fetched byte comes back on a single return path, together with a flag that names the store that served the fetch.

The same block tells the core where its program counter must start. While reset is held, and in the first cycle after reset ends, it offers address 0000h. When the core accepts an interrupt, it offers that source's fixed vector one cycle later. The core names the source on a one-hot input. An input that is not one-hot produces an error pulse and no load.

The strap is captured while reset is held and frozen when reset ends. A change on the pin during the run has no effect.

Top module: `fetch_route`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `pc_load_o` is 1 and `pc_load_addr_o` is 0000h. In the same period `data_valid_o`, `xmem_req_o` and `busy_o` are 0.
- R2: The strap value is taken only while reset is held. Changes on `ext_strap_i` after release do not alter routing.
- R3: With the strap at 1, an accepted fetch at an address from 0000h to 0FFFh raises `irom_req_o` in the same cycle, with `irom_addr_o` equal to the low 12 address bits. In the next cycle `data_valid_o` is 1, `data_o` equals `irom_data_i` and `src_ext_o` is 0.
- R4: With the strap at 1, an accepted fetch at 1000h or above goes to the external port and never raises `irom_req_o`.
- R5: With the strap at 0, every fetch goes to the external port, 0000h included.
- R6: An external fetch raises `xmem_req_o` from the cycle after acceptance, with `xmem_addr_o` holding the fetch address, until `xmem_ready_i` is seen high. In that same cycle `data_valid_o` is 1, `data_o` equals `xmem_data_i` and `src_ext_o` is 1. `xmem_req_o` is 0 in the following cycle.
- R7: `busy_o` is 1 while an external fetch is outstanding. A `fetch_req_i` in that period is ignored: it raises no `irom_req_o` and does not change `xmem_addr_o`.
- R8: An accept strobe `irq_take_i` with exactly one bit `i` set in `irq_src_i` gives, in the next cycle, `pc_load_o` = 1 and `pc_load_addr_o` = 0003h + 8*i. The bit order is: bit 0 external interrupt 0, bit 1 timer 0, bit 2 external interrupt 1, bit 3 timer 1, bit 4 serial port, bit 5 timer 2. This gives 0003h, 000Bh, 0013h, 001Bh, 0023h and 002Bh.
- R9: An accept strobe with zero or several bits set in `irq_src_i` gives, in the next cycle, `irq_err_o` = 1 and `pc_load_o` = 0.
- R10: Apart from the cases in R1, R8 and R9, `pc_load_o` and `irq_err_o` are 0. Each pulse lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ext_strap_i | input | 1 | Boot strap: 1 enables the on-die ROM window |
| fetch_req_i | input | 1 | Fetch request from the core |
| fetch_addr_i | input | 16 | Fetch address |
| busy_o | output | 1 | External fetch outstanding; new requests ignored |
| data_valid_o | output | 1 | Fetched byte valid |
| data_o | output | 8 | Fetched byte |
| src_ext_o | output | 1 | 1 when the byte came from the external port |
| irom_req_o | output | 1 | On-die ROM read strobe |
| irom_addr_o | output | 12 | On-die ROM address |
| irom_data_i | input | 8 | On-die ROM data, one cycle after the strobe |
| xmem_req_o | output | 1 | External program memory request |
| xmem_addr_o | output | 16 | External program memory address |
| xmem_ready_i | input | 1 | External data ready |
| xmem_data_i | input | 8 | External data |
| irq_take_i | input | 1 | Interrupt accept strobe |
| irq_src_i | input | 6 | One-hot accepted source |
| pc_load_o | output | 1 | Program counter load strobe |
| pc_load_addr_o | output | 16 | Program counter load value |
| irq_err_o | output | 1 | Accept strobe with a source that is not one-hot |

## Verification
Two functions can fall in the same cycle: an interrupt vector load and the return of a fetched byte. Both use registered state that advances on the same edge. The bench provokes this by driving an on-die ROM fetch and an accept strobe in the same cycle. In the next cycle it checks the returned byte, the serving store, the load strobe and the vector address together, so that neither path hides or corrupts the other. The strap freeze is judged by changing the pin after reset and then checking where the next fetch is routed.

// File: rtl/fetch_route.sv
module fetch_route #(
  parameter int ADDR_W     = 16,
  parameter int IROM_AW    = 12,
  parameter int DATA_W     = 8,
  parameter int N_VEC      = 6,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_strap_i,
  input  logic              fetch_req_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  output logic              busy_o,
  output logic              data_valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              src_ext_o,
  output logic              irom_req_o,
  output logic [IROM_AW-1:0] irom_addr_o,
  input  logic [DATA_W-1:0] irom_data_i,
  output logic              xmem_req_o,
  output logic [ADDR_W-1:0] xmem_addr_o,
  input  logic              xmem_ready_i,
  input  logic [DATA_W-1:0] xmem_data_i,
  input  logic              irq_take_i,
  input  logic [N_VEC-1:0]  irq_src_i,
  output logic              pc_load_o,
  output logic [ADDR_W-1:0] pc_load_addr_o,
  output logic              irq_err_o
);

  logic              strap_q, int_pend_q, ext_pend_q, boot_q, vec_vld_q, err_q;
  logic [ADDR_W-1:0] xaddr_q, vec_q, vec_addr;
  logic              accept, hit_int, src_one, ext_done;

  assign hit_int    = strap_q && (fetch_addr_i[ADDR_W-1:IROM_AW] == '0);
  assign accept     = fetch_req_i && !ext_pend_q;
  assign irom_req_o = accept && hit_int;
  assign irom_addr_o = fetch_addr_i[IROM_AW-1:0];
  assign src_one    = $onehot(irq_src_i);
  assign ext_done   = ext_pend_q && xmem_ready_i;

  always_comb begin
    vec_addr = '0;
    for (int i = 0; i < N_VEC; i++)
      if (irq_src_i[i]) vec_addr = ADDR_W'(VEC_BASE + VEC_STRIDE * i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) strap_q <= ext_strap_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_pend_q <= 1'b0;
      ext_pend_q <= 1'b0;
      xaddr_q    <= '0;
      boot_q     <= 1'b1;
      vec_vld_q  <= 1'b0;
      err_q      <= 1'b0;
      vec_q      <= '0;
    end else begin
      int_pend_q <= irom_req_o;
      if (accept && !hit_int) begin
        ext_pend_q <= 1'b1;
        xaddr_q    <= fetch_addr_i;
      end else if (xmem_ready_i) begin
        ext_pend_q <= 1'b0;
      end
      boot_q    <= 1'b0;
      vec_vld_q <= irq_take_i && src_one;
      err_q     <= irq_take_i && !src_one;
      if (irq_take_i && src_one) vec_q <= vec_addr;
    end
  end

  assign busy_o         = ext_pend_q;
  assign xmem_req_o     = ext_pend_q;
  assign xmem_addr_o    = xaddr_q;
  assign data_valid_o   = int_pend_q || ext_done;
  assign data_o         = ext_done ? xmem_data_i : irom_data_i;
  assign src_ext_o      = ext_done;
  assign pc_load_o      = boot_q || vec_vld_q;
  assign pc_load_addr_o = boot_q ? '0 : vec_q;
  assign irq_err_o      = err_q;

  // R3
  int_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irom_req_o |=> data_valid_o && !src_ext_o);
  // R6
  ext_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xmem_req_o && !xmem_ready_i |=> xmem_req_o && $stable(xmem_addr_o));
  // R6
  ext_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xmem_req_o && xmem_ready_i |=> !xmem_req_o);
  // R7
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !irom_req_o);
  // R8
  vec_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take_i && $onehot(irq_src_i) |=> pc_load_o && !irq_err_o);
  // R9
  vec_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take_i && !$onehot(irq_src_i) |=> irq_err_o && !pc_load_o);
  // R10
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_take_i |=> !irq_err_o);

endmodule

// File: tb/tb_fetch_route.sv
module tb_fetch_route;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0, ext_strap_i = 1'b1;
  logic        fetch_req_i = 1'b0;
  logic [15:0] fetch_addr_i = '0;
  logic        busy_o, data_valid_o, src_ext_o, irom_req_o, xmem_req_o;
  logic [7:0]  data_o, irom_data_i, xmem_data_i;
  logic [11:0] irom_addr_o;
  logic [15:0] xmem_addr_o, pc_load_addr_o;
  logic        xmem_ready_i = 1'b0, irq_take_i = 1'b0;
  logic [5:0]  irq_src_i = '0;
  logic        pc_load_o, irq_err_o;
  int          n_run = 0, n_fail = 0;

  fetch_route dut (
    .clk(clk), .rst_n(rst_n), .ext_strap_i(ext_strap_i),
    .fetch_req_i(fetch_req_i), .fetch_addr_i(fetch_addr_i), .busy_o(busy_o),
    .data_valid_o(data_valid_o), .data_o(data_o), .src_ext_o(src_ext_o),
    .irom_req_o(irom_req_o), .irom_addr_o(irom_addr_o), .irom_data_i(irom_data_i),
    .xmem_req_o(xmem_req_o), .xmem_addr_o(xmem_addr_o), .xmem_ready_i(xmem_ready_i),
    .xmem_data_i(xmem_data_i), .irq_take_i(irq_take_i), .irq_src_i(irq_src_i),
    .pc_load_o(pc_load_o), .pc_load_addr_o(pc_load_addr_o), .irq_err_o(irq_err_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) irom_data_i <= irom_addr_o[7:0] ^ 8'h3C;
  assign xmem_data_i = xmem_addr_o[7:0] ^ 8'hA5;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic t_reset(input logic strap);
    @(negedge clk);
    rst_n = 1'b0; ext_strap_i = strap;
    fetch_req_i = 1'b0; irq_take_i = 1'b0; xmem_ready_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 load in reset", pc_load_o, 1);
    chk("R1 addr in reset", pc_load_addr_o, 0);
    chk("R1 valid in reset", data_valid_o, 0);
    chk("R1 xreq in reset", xmem_req_o, 0);
    chk("R1 busy in reset", busy_o, 0);
    rst_n = 1'b1;
    #1 chk("R1 load after release", pc_load_o, 1);
    chk("R1 addr after release", pc_load_addr_o, 0);
    @(negedge clk);
    chk("R10 load quiet", pc_load_o, 0);
  endtask

  task automatic fetch_int(input logic [15:0] a, input string tag);
    @(negedge clk);
    fetch_req_i = 1'b1; fetch_addr_i = a;
    #1 chk({tag, " irom req"}, irom_req_o, 1);
    chk({tag, " irom addr"}, irom_addr_o, a[11:0]);
    @(negedge clk);
    fetch_req_i = 1'b0;
    chk({tag, " valid"}, data_valid_o, 1);
    chk({tag, " data"}, data_o, a[7:0] ^ 8'h3C);
    chk({tag, " src"}, src_ext_o, 0);
    chk({tag, " no xreq"}, xmem_req_o, 0);
  endtask

  task automatic fetch_ext(input logic [15:0] a, input int waits, input string tag);
    @(negedge clk);
    fetch_req_i = 1'b1; fetch_addr_i = a;
    #1 chk({tag, " no irom req"}, irom_req_o, 0);
    @(negedge clk);
    fetch_req_i = 1'b0;
    chk({tag, " xreq"}, xmem_req_o, 1);
    chk({tag, " xaddr"}, xmem_addr_o, a);
    chk("R7 busy", busy_o, 1);
    chk({tag, " not valid yet"}, data_valid_o, 0);
    for (int k = 0; k < waits; k++) begin
      fetch_req_i = 1'b1; fetch_addr_i = 16'h0005;
      #1 chk("R7 ignored irom", irom_req_o, 0);
      @(negedge clk);
      fetch_req_i = 1'b0;
      chk("R6 xreq held", xmem_req_o, 1);
      chk("R7 xaddr kept", xmem_addr_o, a);
    end
    xmem_ready_i = 1'b1;
    #1 chk("R6 valid", data_valid_o, 1);
    chk("R6 data", data_o, a[7:0] ^ 8'hA5);
    chk("R6 src", src_ext_o, 1);
    @(negedge clk);
    xmem_ready_i = 1'b0;
    chk("R6 xreq drop", xmem_req_o, 0);
    chk("R7 busy clear", busy_o, 0);
  endtask

  task automatic irq(input logic [5:0] src, input logic ok, input logic [15:0] vec, input string tag);
    @(negedge clk);
    irq_take_i = 1'b1; irq_src_i = src;
    @(negedge clk);
    irq_take_i = 1'b0;
    chk({tag, " load"}, pc_load_o, ok);
    chk({tag, " err"}, irq_err_o, !ok);
    if (ok) chk({tag, " vector"}, pc_load_addr_o, vec);
    @(negedge clk);
    chk("R10 load pulse ends", pc_load_o, 0);
    chk("R10 err pulse ends", irq_err_o, 0);
  endtask

  task automatic collide();
    @(negedge clk);
    fetch_req_i = 1'b1; fetch_addr_i = 16'h0100;
    irq_take_i = 1'b1; irq_src_i = 6'b010000;
    @(negedge clk);
    fetch_req_i = 1'b0; irq_take_i = 1'b0;
    chk("R3 collide valid", data_valid_o, 1);
    chk("R3 collide data", data_o, 8'h00 ^ 8'h3C);
    chk("R3 collide src", src_ext_o, 0);
    chk("R8 collide load", pc_load_o, 1);
    chk("R8 collide vector", pc_load_addr_o, 16'h0023);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset(1'b1);
    fetch_int(16'h0000, "R3");
    fetch_int(16'h0FFF, "R3");
    fetch_ext(16'h1000, 2, "R4");
    fetch_ext(16'hFFFF, 0, "R4");
    for (int i = 0; i < 6; i++)
      irq(6'(1 << i), 1'b1, 16'(3 + 8 * i), "R8");
    irq(6'b000000, 1'b0, 16'h0, "R9");
    irq(6'b000011, 1'b0, 16'h0, "R9");
    collide();
    ext_strap_i = 1'b0;
    fetch_int(16'h0ABC, "R2");
    t_reset(1'b0);
    fetch_ext(16'h0000, 1, "R5");
    fetch_ext(16'h0FFF, 0, "R5");
    ext_strap_i = 1'b1;
    fetch_ext(16'h0003, 0, "R2");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule